// File: doc/BRIEF.md
# Tri-State PWM Half-Bridge Gate Controller

This block is the digital core of a synchronous half-bridge driver. It turns an enable, a two-bit three-level PWM command, a zero-current-detect enable, a zero-crossing comparator flag and two gate-discharged feedback flags into high-side and low-side gate commands. Every input is asynchronous to the block clock and passes through a two-flop synchronizer first.

Hand-overs are break-before-make. The outgoing gate is dropped at once. The incoming gate rises only after feedback confirms that the outgoing gate has discharged, and then only after a non-overlap timer of `NOL_CYC` cycles has run. When zero-current detection is enabled during a low phase, the comparator flag is blanked for `BLANK_CYC` cycles after the low-side gate rises. After that window a flag latches a low-side cutoff that lasts until the command leaves low. The mid command parks both switches off.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With `en_i` low, both gate outputs are low regardless of `pwm_i`, `zcd_en_ni` and `zc_flag_i`.
- R2: `pwm_i` = 2'b11 (high) drives `hs_gate_o` high and `ls_gate_o` low.
- R3: `pwm_i` = 2'b01 or 2'b10 (mid) drives both gates low, and `ls_gate_o` stays low for as long as mid persists.
- R4: `pwm_i` = 2'b00 (low) with `zcd_en_ni` high drives `ls_gate_o` high and `hs_gate_o` low, and `zc_flag_i` has no effect.
- R5: `pwm_i` = 2'b00 with `zcd_en_ni` low turns `ls_gate_o` on, then off once a synchronized `zc_flag_i` is seen after blanking.
- R6: `zc_flag_i` is ignored for `BLANK_CYC` cycles after `ls_gate_o` rises. With the flag held high throughout, `ls_gate_o` stays high for exactly `BLANK_CYC`+1 cycles.
- R7: A zero-current cutoff holds `ls_gate_o` low until `pwm_i` leaves 2'b00. The next low phase turns the low side on again.
- R8: An incoming gate never rises while the outgoing gate's discharged flag (`hs_low_i` / `ls_low_i`) is low.
- R9: With feedback that is immediate, the incoming gate rises exactly `NOL_CYC`+3 cycles after the outgoing gate falls (two synchronizer stages, the timer, one register).
- R10: `hs_gate_o` and `ls_gate_o` are never high in the same cycle.
- R11: A change of `pwm_i` is visible at a gate output on the third rising clock edge after it is applied, provided the non-overlap timer has already expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low forces both gates off |
| pwm_i | input | 2 | PWM command: 00 low, 01/10 mid, 11 high |
| zcd_en_ni | input | 1 | Zero-current-detect enable, active low; its synchronizer resets to the disabled level |
| zc_flag_i | input | 1 | Zero-crossing comparator output |
| hs_low_i | input | 1 | High-side gate reported below its low threshold |
| ls_low_i | input | 1 | Low-side gate reported below its low threshold |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |

## Verification
The hardest states to reach are the ones where timing depends on feedback. To show that a hand-over waits on the discharged flag, the bench holds one gate's flag low after commanding the other gate. It then checks that the incoming gate stays off, and measures how long it takes to rise once the flag is released. The blanking window is measured by holding the comparator flag high before the low phase starts and counting the low-side pulse width. The cutoff latch is tested by staying low after the cutoff, then passing through mid and returning to low.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  typedef enum logic [1:0] {CMD_LOW, CMD_MID, CMD_HIGH} cmd_e;

  function automatic cmd_e decode_cmd(input logic [1:0] code);
    case (code)
      2'b00:   return CMD_LOW;
      2'b11:   return CMD_HIGH;
      default: return CMD_MID;
    endcase
  endfunction
endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hb_zcd_guard.sv
`timescale 1ns/1ps
module hb_zcd_guard #(
  parameter int unsigned BLANK_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ls_gate_i,
  input  logic cmd_low_i,
  input  logic zcd_on_i,
  input  logic zc_i,
  output logic cut_o
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

  logic [BW-1:0] blank_cnt_q;
  logic          blank_done, cut_set, cut_q;

  // blanking window restarts on every low-side turn-on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     blank_cnt_q <= '0;
    else if (!ls_gate_i)             blank_cnt_q <= '0;
    else if (blank_cnt_q != BLANK_END) blank_cnt_q <= blank_cnt_q + 1'b1;
  end

  assign blank_done = (blank_cnt_q == BLANK_END);
  assign cut_set    = cmd_low_i & zcd_on_i & ls_gate_i & blank_done & zc_i;

  // cutoff persists for the rest of the low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cut_q <= 1'b0;
    else if (!cmd_low_i) cut_q <= 1'b0;
    else if (cut_set)    cut_q <= 1'b1;
  end

  assign cut_o = cut_set | cut_q;

  // R6
  no_cut_in_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_gate_i) |=> !cut_q);
endmodule

// File: rtl/hb_handover.sv
`timescale 1ns/1ps
module hb_handover #(
  parameter int unsigned NOL_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_hs_i,
  input  logic want_ls_i,
  input  logic hs_low_i,
  input  logic ls_low_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);
  localparam int unsigned NW = $clog2(NOL_CYC + 1);
  localparam logic [NW-1:0] NOL_END = NW'(NOL_CYC);

  logic [NW-1:0] nol_cnt_q;
  logic          both_off, nol_done;
  logic          hs_d, ls_d;

  // timer runs only once both gates are commanded off and confirmed low
  assign both_off = ~hs_gate_o & ~ls_gate_o & hs_low_i & ls_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  nol_cnt_q <= '0;
    else if (!both_off)           nol_cnt_q <= '0;
    else if (nol_cnt_q != NOL_END) nol_cnt_q <= nol_cnt_q + 1'b1;
  end

  assign nol_done = both_off & (nol_cnt_q == NOL_END);

  always_comb begin
    hs_d = want_hs_i & (hs_gate_o | nol_done);
    ls_d = want_ls_i & (ls_gate_o | nol_done);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_gate_o <= 1'b0;
      ls_gate_o <= 1'b0;
    end else begin
      hs_gate_o <= hs_d;
      ls_gate_o <= ls_d;
    end
  end

  // R10
  no_shoot_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_gate_o && ls_gate_o));
  // R8
  ls_waits_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_gate_o) |-> $past(hs_low_i));
  // R8
  hs_waits_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_gate_o) |-> $past(ls_low_i));
endmodule

// File: rtl/hb_gate_ctrl.sv
`timescale 1ns/1ps
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned NOL_CYC   = 2,
  parameter int unsigned BLANK_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] pwm_i,
  input  logic       zcd_en_ni,
  input  logic       zc_flag_i,
  input  logic       hs_low_i,
  input  logic       ls_low_i,
  output logic       hs_gate_o,
  output logic       ls_gate_o
);
  localparam int unsigned SW = 7;
  // {en, pwm[1:0], zcd_en_n, zc, hs_low, ls_low}; zcd starts disabled
  localparam logic [SW-1:0] SYNC_RST = 7'b0001000;

  logic [SW-1:0] raw_in, sync_q;
  logic          en_s, zcd_en_n_s, zc_s, hs_low_s, ls_low_s;
  logic [1:0]    pwm_s;
  cmd_e          cmd;
  logic          cmd_low, cut, want_hs, want_ls;

  assign raw_in = {en_i, pwm_i, zcd_en_ni, zc_flag_i, hs_low_i, ls_low_i};

  hb_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_q)
  );

  assign {en_s, pwm_s, zcd_en_n_s, zc_s, hs_low_s, ls_low_s} = sync_q;
  assign cmd     = decode_cmd(pwm_s);
  assign cmd_low = (cmd == CMD_LOW);

  hb_zcd_guard #(.BLANK_CYC(BLANK_CYC)) u_zcd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ls_gate_i(ls_gate_o),
    .cmd_low_i(cmd_low),
    .zcd_on_i (~zcd_en_n_s),
    .zc_i     (zc_s),
    .cut_o    (cut)
  );

  assign want_hs = en_s & (cmd == CMD_HIGH);
  assign want_ls = en_s & cmd_low & ~cut;

  hb_handover #(.NOL_CYC(NOL_CYC)) u_hand (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .want_hs_i(want_hs),
    .want_ls_i(want_ls),
    .hs_low_i (hs_low_s),
    .ls_low_i (ls_low_s),
    .hs_gate_o(hs_gate_o),
    .ls_gate_o(ls_gate_o)
  );

  // R1
  dis_gates_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> (!hs_gate_o && !ls_gate_o));
  // R3
  mid_gates_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MID) |=> (!hs_gate_o && !ls_gate_o));
  // R2
  high_no_ls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_HIGH) |=> !ls_gate_o);
endmodule

// File: tb/hb_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hb_gate_ctrl_bench;
  localparam int unsigned NOL   = 2;
  localparam int unsigned BLANK = 2;
  localparam int unsigned NV    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, zcd_n = 1'b1, zc = 1'b0;
  logic [1:0] pwm = 2'b01;
  logic       hs_stuck = 1'b0, ls_stuck = 1'b0;
  logic       hs_g, ls_g, hs_low, ls_low;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  // gate feedback model: discharged immediately unless forced
  assign hs_low = ~hs_g & ~hs_stuck;
  assign ls_low = ~ls_g & ~ls_stuck;

  hb_gate_ctrl #(.NOL_CYC(NOL), .BLANK_CYC(BLANK)) u_hb_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pwm_i(pwm), .zcd_en_ni(zcd_n),
    .zc_flag_i(zc), .hs_low_i(hs_low), .ls_low_i(ls_low),
    .hs_gate_o(hs_g), .ls_gate_o(ls_g)
  );

  // {en, pwm[1:0], zcd_en_n, zc, exp_hs, exp_ls}
  localparam logic [6:0] VEC [NV] = '{
    7'b1_11_1_0_1_0,  // R2
    7'b1_01_1_0_0_0,  // R3
    7'b1_00_1_1_0_1,  // R4 flag ignored
    7'b1_10_1_0_0_0,  // R3 code 10
    7'b0_11_1_0_0_0,  // R1
    7'b0_00_0_1_0_0,  // R1
    7'b1_00_0_1_0_0,  // R5 cut after blank
    7'b1_11_0_1_1_0   // R2
  };
  localparam int VREQ [NV] = '{2, 3, 4, 3, 1, 1, 5, 2};

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int t_hs, t_ls, w;
    // reset state
    cyc(3);
    chk("reset hs R1", int'(hs_g), 0);
    chk("reset ls R1", int'(ls_g), 0);
    rst_n = 1'b1;
    cyc(4);

    for (int i = 0; i < NV; i++) begin
      {en, pwm, zcd_n, zc} = VEC[i][6:2];
      cyc(12);
      chk($sformatf("vec%0d hs R%0d", i, VREQ[i]), int'(hs_g), int'(VEC[i][1]));
      chk($sformatf("vec%0d ls R%0d", i, VREQ[i]), int'(ls_g), int'(VEC[i][0]));
    end

    // R11: latency from mid to high with timer expired
    en = 1'b1; zcd_n = 1'b1; zc = 1'b0; pwm = 2'b01;
    cyc(12);
    pwm = 2'b11;
    cyc(2);
    chk("latency edge2 R11", int'(hs_g), 0);
    cyc(1);
    chk("latency edge3 R11", int'(hs_g), 1);

    // R9: hand-over gap with immediate feedback
    cyc(6);
    pwm = 2'b00;
    t_hs = -1; t_ls = -1;
    for (int n = 1; n <= 30; n++) begin
      cyc(1);
      if (t_hs < 0 && !hs_g) t_hs = n;
      if (t_ls < 0 && ls_g)  t_ls = n;
      if (hs_g && ls_g) chk("overlap R10", 1, 0);
    end
    chk("hand-over gap R9", t_ls - t_hs, NOL + 3);

    // R8: low-side feedback stuck, high side must wait
    ls_stuck = 1'b1;
    pwm = 2'b11;
    cyc(30);
    chk("hs held by fb R8", int'(hs_g), 0);
    chk("ls dropped R8", int'(ls_g), 0);
    ls_stuck = 1'b0;
    cyc(8);
    chk("hs after fb release R8", int'(hs_g), 1);

    // R8: high-side feedback stuck, low side must wait
    hs_stuck = 1'b1;
    pwm = 2'b00;
    cyc(30);
    chk("ls held by fb R8", int'(ls_g), 0);
    hs_stuck = 1'b0;
    cyc(8);
    chk("ls after fb release R8", int'(ls_g), 1);

    // R6: flag held high before the low phase; pulse width = BLANK+1
    pwm = 2'b01; zcd_n = 1'b0; zc = 1'b1;
    cyc(12);
    pwm = 2'b00;
    w = 0;
    for (int n = 0; n < 30; n++) begin
      cyc(1);
      if (ls_g) w++;
    end
    chk("blank pulse width R6", w, BLANK + 1);
    // R7: cutoff holds during the same low phase
    zc = 1'b0;
    cyc(20);
    chk("cut held in low R7", int'(ls_g), 0);
    // R7: mid then low re-arms
    pwm = 2'b01;
    cyc(10);
    chk("mid keeps ls off R3", int'(ls_g), 0);
    zc = 1'b1;
    pwm = 2'b00;
    w = 0;
    for (int n = 0; n < 30; n++) begin
      cyc(1);
      if (ls_g) w++;
    end
    chk("re-armed pulse R7", w, BLANK + 1);

    // R5: late flag cuts the low side
    pwm = 2'b01; zc = 1'b0;
    cyc(12);
    pwm = 2'b00;
    cyc(20);
    chk("ls on before flag R5", int'(ls_g), 1);
    zc = 1'b1;
    cyc(5);
    chk("ls off after flag R5", int'(ls_g), 0);

    // R4: detect disabled, flag toggling has no effect
    pwm = 2'b01; zc = 1'b0; zcd_n = 1'b1;
    cyc(12);
    pwm = 2'b00;
    cyc(12);
    zc = 1'b1;
    cyc(10);
    chk("flag ignored R4", int'(ls_g), 1);
    chk("hs off in low R4", int'(hs_g), 0);

    // R1: dropping enable mid-phase
    en = 1'b0;
    cyc(6);
    chk("en off ls R1", int'(ls_g), 0);

    finish_run();
  end
endmodule